// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single line. It samples the line 16 times per bit period and accepts 7 or 8 data bits, least significant bit first. Each frame may carry a parity bit and ends with one or two stop bits. Every completed frame is stored in a data register. A three-bit status register reports whether that byte is good data (data-ready), a stop-bit fault (framing error) or a parity mismatch (parity error).

Software reaches the block through a small register bus with plain strobes. A read is combinational, and a write takes effect on the clock edge. No streaming interface is involved, so there is no back-pressure. When a byte arrives before software has taken the previous one, it overwrites the data register. The error flags stay set until software clears them, and while either is set the receiver accepts no new frame. A standby input clears the status flags and aborts any frame in progress.

The bus has three addresses. Address 0 is the control register, read and write: bit0 enable, bit1 eight-bit data (0 means seven), bit2 parity on, bit3 odd parity (0 means even), bit4 two stop bits. Address 1 is the status register: bit0 data-ready, bit1 framing error, bit2 parity error. Address 2 is the received data, read only. Any other address reads as zero.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, reads at addresses 0, 1 and 2 all return 0.
- R2: A valid frame stores its data bits (LSB first) at address 2 and sets status bit0. In seven-bit mode the stored bit7 is 0.
- R3: A low level on the line that is high again at the middle of the start bit is rejected. No frame is received and no flag changes.
- R4: With parity on, status bit2 is set when the count of ones in the data bits plus the parity bit is odd under even parity, or even under odd parity.
- R5: Status bit1 is set when the first stop bit is sampled low. In two-stop mode the second stop bit is not checked, and a low second stop bit neither flags an error nor starts a new frame.
- R6: After a frame with a framing or parity error, the byte is still stored at address 2 and status bit0 is not set.
- R7: While status bit1 or bit2 is 1, frames on the line are not received: neither the data register nor any flag changes.
- R8: Writing 0 to a status bit clears it only if a status read has returned that bit as 1 since it was last set. Without such a read the write has no effect. Writing 1 never changes a flag.
- R9: Reading address 2 does not clear status bit0.
- R10: Clearing the enable bit leaves all status flags unchanged. While it is 0, frames on the line are ignored.
- R11: Asserting standby clears all three status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Clears the status flags and aborts reception while high |
| rx_in | input | 1 | Serial line, idle high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 means write, 0 means read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |

## Verification
The assertions assume that control bits change only while the line is idle. They also assume the line holds each bit for a whole bit period of 16 sample ticks, so the sample taken at the middle of each bit sees a settled level. The bench changes configuration only between frames and drives every bit for exactly one bit period. It leaves at least one idle bit after each frame, so the start of a frame is never mistaken for the tail of the previous one. Glitches are short low pulses that end well before the middle of the start bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int OSR   = 16;
  localparam int OSR_W = $clog2(OSR);
  localparam int DW    = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2
  } rx_state_t;

  typedef struct packed {
    logic two_stop;
    logic par_odd;
    logic par_en;
    logic len8;
    logic enable;
  } rx_cfg_t;
endpackage

// File: rtl/rx_front.sv
module rx_front #(
  parameter int CLKS_PER_TICK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_s,
  output logic tick
);
  localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [CW-1:0] TOP = CW'(CLKS_PER_TICK - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_in};
  end
  assign rx_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_q <= '0;
    else if (div_q == TOP) div_q <= '0;
    else                 div_q <= div_q + 1'b1;
  end
  assign tick = (div_q == TOP);
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import serial_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_s,
  input  rx_cfg_t       cfg,
  input  logic          halt,
  input  logic          abort,
  output logic          done,
  output logic          fe,
  output logic          pe,
  output logic [DW-1:0] data
);
  localparam logic [OSR_W-1:0] MID  = OSR_W'(OSR/2 - 1);
  localparam logic [OSR_W-1:0] LAST = OSR_W'(OSR - 1);
  localparam int NW = $clog2(DW);

  rx_state_t        st;
  logic [OSR_W-1:0] cnt;
  logic [NW-1:0]    nbit;
  logic [DW-1:0]    shreg;
  logic             par_acc;
  logic [NW-1:0]    last_idx;

  assign last_idx = cfg.len8 ? NW'(DW-1) : NW'(DW-2);
  assign data     = cfg.len8 ? shreg : {1'b0, shreg[DW-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; nbit <= '0; shreg <= '0;
      par_acc <= 1'b0; done <= 1'b0; fe <= 1'b0; pe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st <= S_IDLE;
      end else if (tick) begin
        case (st)
          S_IDLE: if (!halt && !rx_s) begin st <= S_START; cnt <= '0; end
          S_START:
            if (cnt == MID) begin
              cnt <= '0; nbit <= '0; par_acc <= 1'b0;
              st  <= rx_s ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          S_DATA:
            if (cnt == LAST) begin
              cnt     <= '0;
              shreg   <= {rx_s, shreg[DW-1:1]};
              par_acc <= par_acc ^ rx_s;
              if (nbit == last_idx) st <= cfg.par_en ? S_PAR : S_STOP;
              else nbit <= nbit + 1'b1;
            end else cnt <= cnt + 1'b1;
          S_PAR:
            if (cnt == LAST) begin
              cnt <= '0; par_acc <= par_acc ^ rx_s; st <= S_STOP;
            end else cnt <= cnt + 1'b1;
          S_STOP:
            if (cnt == LAST) begin
              cnt  <= '0;
              done <= 1'b1;
              fe   <= !rx_s;
              pe   <= cfg.par_en && (par_acc != cfg.par_odd);
              st   <= cfg.two_stop ? S_STOP2 : S_IDLE;
            end else cnt <= cnt + 1'b1;
          S_STOP2:
            if (cnt == LAST) begin cnt <= '0; st <= S_IDLE; end
            else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R7
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && halt) |=> (st == S_IDLE));

  // R3
  glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick && cnt == MID && rx_s && !abort) |=> (st == S_IDLE && !done));

  // R10
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !done);
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import serial_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          done,
  input  logic          fe,
  input  logic          pe,
  input  logic [DW-1:0] data_in,
  output rx_cfg_t       cfg,
  output logic          halt
);
  localparam int NF = 3;   // bit0 ready, bit1 framing, bit2 parity

  logic [NF-1:0] flags, armed, set_vec;
  logic [DW-1:0] data_q;
  logic          rd_stat, wr_stat, wr_ctrl;
  logic [2:0]    unused_wbits;

  assign unused_wbits = bus_wdata[7:5];
  assign rd_stat = bus_sel && !bus_wr && bus_addr == ADDR_STAT;
  assign wr_stat = bus_sel &&  bus_wr && bus_addr == ADDR_STAT;
  assign wr_ctrl = bus_sel &&  bus_wr && bus_addr == ADDR_CTRL;
  assign set_vec = done ? {pe, fe, !(fe || pe)} : '0;
  assign halt    = flags[1] || flags[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg <= '0;
    else if (wr_ctrl) cfg <= bus_wdata[4:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (done) data_q <= data_in;
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i] <= 1'b0; armed[i] <= 1'b0;
      end else if (standby) begin
        flags[i] <= 1'b0; armed[i] <= 1'b0;
      end else if (set_vec[i]) begin
        flags[i] <= 1'b1; armed[i] <= 1'b0;
      end else if (wr_stat && !bus_wdata[i] && armed[i]) begin
        flags[i] <= 1'b0; armed[i] <= 1'b0;
      end else if (rd_stat && flags[i]) begin
        armed[i] <= 1'b1;
      end
    end

    // R8
    flag_clear_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> ($past(standby) || $past(wr_stat && !bus_wdata[i])));
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = {3'b000, cfg};
      ADDR_STAT: bus_rdata = {5'b00000, flags};
      ADDR_DATA: bus_rdata = data_q;
      default:   bus_rdata = '0;
    endcase
  end

  // R6
  ready_only_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(done && !fe && !pe));

  // R5
  ferr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(done && fe));

  // R4
  perr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> $past(done && pe));

  // R10
  enable_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.enable && !standby && !wr_stat && !done) |=> $stable(flags));

  // R11
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (flags == '0));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       rx_in,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  logic          rx_s, tick, done, fe, pe, halt, abort;
  logic [DW-1:0] rx_data;
  rx_cfg_t       cfg;

  assign abort = standby || !cfg.enable;

  rx_front #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_front (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_s(rx_s), .tick(tick)
  );

  rx_frame_engine u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s), .cfg(cfg),
    .halt(halt), .abort(abort), .done(done), .fe(fe), .pe(pe), .data(rx_data)
  );

  rx_status_regs u_regs (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .fe(fe), .pe(pe), .data_in(rx_data),
    .cfg(cfg), .halt(halt)
  );
endmodule

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
  localparam int CPT = 4;
  localparam int BITP = 16 * CPT;

  logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0, rx_in = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata, rd;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  serial_rx_core #(.CLKS_PER_TICK(CPT)) uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .rx_in(rx_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] exp_data(input logic [7:0] d, input bit len8);
    return len8 ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic [7:0] ctrl_val(input bit len8, pen, odd, two);
    return {3'b000, two, odd, pen, len8, 1'b1};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic hold(input logic v);
    rx_in = v;
    repeat (BITP) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit len8, pen, odd, two,
                      input bit bad_stop, bad_par, bad_stop2);
    logic pb;
    @(negedge clk);
    hold(1'b0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) hold(d[i]);
    if (pen) begin
      pb = ^exp_data(d, len8);
      if (odd) pb = ~pb;
      if (bad_par) pb = ~pb;
      hold(pb);
    end
    hold(!bad_stop);
    if (two) hold(!bad_stop2);
    hold(1'b1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    bus_read(2'd0, rd); check("R1 ctrl", rd, 8'h00);
    bus_read(2'd1, rd); check("R1 stat", rd, 8'h00);
    bus_read(2'd2, rd); check("R1 data", rd, 8'h00);

    // R2 R9 R8 random valid frames
    for (int n = 0; n < 14; n++) begin
      logic [7:0] d;
      bit l8, pe_on, od, tw;
      d = 8'($urandom); l8 = 1'($urandom); pe_on = 1'($urandom);
      od = 1'($urandom); tw = 1'($urandom);
      bus_write(2'd0, ctrl_val(l8, pe_on, od, tw));
      send(d, l8, pe_on, od, tw, 1'b0, 1'b0, 1'b0);
      bus_read(2'd1, rd); check("R2 ready", rd, 8'h01);
      bus_read(2'd2, rd); check("R2 data", rd, exp_data(d, l8));
      bus_read(2'd1, rd); check("R9 ready kept", rd, 8'h01);
      bus_write(2'd1, 8'h00);
      bus_read(2'd1, rd); check("R8 cleared", rd, 8'h00);
    end

    // R8 write 0 without prior read, and write 1
    bus_write(2'd0, ctrl_val(1, 0, 0, 0));
    send(8'h5A, 1, 0, 0, 0, 0, 0, 0);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, rd); check("R8 no read", rd, 8'h01);
    bus_write(2'd1, 8'h07);
    bus_read(2'd1, rd); check("R8 write one", rd, 8'h01);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, rd); check("R8 armed clear", rd, 8'h00);

    // R5 R6 framing error, then R7 halt, R10 enable
    send(8'hA5, 1, 0, 0, 0, 1, 0, 0);
    bus_read(2'd1, rd); check("R5 ferr", rd, 8'h02);
    bus_read(2'd2, rd); check("R6 stored", rd, 8'hA5);
    send(8'h3C, 1, 0, 0, 0, 0, 0, 0);
    bus_read(2'd1, rd); check("R7 halted flags", rd, 8'h02);
    bus_read(2'd2, rd); check("R7 halted data", rd, 8'hA5);
    bus_write(2'd0, 8'h00);
    bus_read(2'd1, rd); check("R10 flag kept", rd, 8'h02);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, rd); check("R8 ferr clear", rd, 8'h00);
    send(8'h77, 1, 0, 0, 0, 0, 0, 0);
    bus_read(2'd1, rd); check("R10 disabled", rd, 8'h00);
    bus_read(2'd2, rd); check("R10 data kept", rd, 8'hA5);

    // R4 parity errors even and odd, both errors
    bus_write(2'd0, ctrl_val(1, 1, 0, 0));
    send(8'h81, 1, 1, 0, 0, 0, 1, 0);
    bus_read(2'd1, rd); check("R4 even perr", rd, 8'h04);
    bus_read(2'd2, rd); check("R6 perr stored", rd, 8'h81);
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, ctrl_val(0, 1, 1, 0));
    send(8'h13, 0, 1, 1, 0, 0, 1, 0);
    bus_read(2'd1, rd); check("R4 odd perr", rd, 8'h04);
    bus_read(2'd2, rd); check("R6 seven bit", rd, 8'h13);
    bus_write(2'd1, 8'h00);
    send(8'h6E, 0, 1, 1, 0, 1, 1, 0);
    bus_read(2'd1, rd); check("R5 R4 both", rd, 8'h06);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, rd); check("R8 both clear", rd, 8'h00);

    // R5 bad second stop bit ignored
    bus_write(2'd0, ctrl_val(1, 0, 0, 1));
    send(8'hC3, 1, 0, 0, 1, 0, 0, 1);
    bus_read(2'd1, rd); check("R5 second stop", rd, 8'h01);
    bus_read(2'd2, rd); check("R5 data", rd, 8'hC3);
    bus_write(2'd1, 8'h00);
    send(8'h29, 1, 0, 0, 1, 0, 0, 0);
    bus_read(2'd1, rd); check("R5 next frame", rd, 8'h01);
    bus_read(2'd2, rd); check("R5 next data", rd, 8'h29);
    bus_read(2'd1, rd);
    bus_write(2'd1, 8'h00);

    // R3 glitch
    @(negedge clk); rx_in = 1'b0;
    repeat (3 * CPT) @(negedge clk);
    rx_in = 1'b1;
    repeat (4 * BITP) @(negedge clk);
    bus_read(2'd1, rd); check("R3 glitch", rd, 8'h00);
    bus_read(2'd2, rd); check("R3 data", rd, 8'h29);

    // R11 standby
    send(8'h0F, 1, 0, 0, 1, 1, 0, 0);
    bus_read(2'd1, rd); check("R11 before", rd, 8'h02);
    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
    bus_read(2'd1, rd); check("R11 standby", rd, 8'h00);
    send(8'hE1, 1, 0, 0, 1, 0, 0, 0);
    bus_read(2'd1, rd); check("R11 resumed", rd, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule